// File: doc/BRIEF.md
# Compare-Latch Conditional Branch Resolver

This block settles conditional branches for a small 32-bit processor whose branches never look at status flags. Instead, a separate compare operation hands the block two raw register values, which it holds in a pair of operand latches. A later branch operation supplies its own address and its 16-bit instruction word. The block compares the two held operands again under the relation that the branch selects. It then reports whether the branch is taken and which address comes next.

The relation is picked by a 4-bit selector inside the instruction word, and ten signed and unsigned relations are defined. A selector outside that set makes the block flag an illegal instruction and return the branch's own address, so that a handler can find the faulting instruction. The taken target is formed from a signed 10-bit field counted in 16-bit units and is relative to the address just past the branch.

Results are registered and carry a one-cycle valid pulse. Fetch, the register file and pipeline flushing stay outside the block.

Top module: `cond_branch_unit`

## Requirements
- R1: After synchronous reset, res_valid, res_taken, res_illegal and res_next_pc are all 0, and both operand latches hold 0, so a first branch with selector 0 (equal) is taken.
- R2: A compare strobe copies cmp_lhs into latch A and cmp_rhs into latch B at that clock edge, and it produces no result output. While cmp_valid is low, the latches keep their values whatever cmp_lhs and cmp_rhs carry.
- R3: When a compare and a branch are strobed in the same cycle, the branch is evaluated against the latch contents from before that compare.
- R4: Each relation is evaluated as A relation B. The selector values are: 0 equal, 1 not equal, 2 signed less, 3 signed greater, 4 unsigned less, 5 unsigned greater, 6 signed greater-or-equal, 7 signed less-or-equal, 8 unsigned greater-or-equal, 9 unsigned less-or-equal.
- R5: For a taken branch, res_next_pc equals br_pc + 2 + (sign-extended br_insn[9:0]) × 2, computed modulo 2^32.
- R6: For a legal branch that is not taken, res_next_pc equals br_pc + 2 and res_taken is 0.
- R7: Selector values 10 to 15 give res_illegal = 1, res_taken = 0 and res_next_pc = br_pc.
- R8: The selector is read from br_insn[13:10]. A branch strobe is accepted only when br_insn[15:14] = 2'b11. Any other word produces no valid result and changes no output.
- R9: res_valid is high for exactly the one cycle after each accepted branch strobe and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Compare strobe; loads both operand latches |
| cmp_lhs | input | DATA_W | Left operand, stored in latch A |
| cmp_rhs | input | DATA_W | Right operand, stored in latch B |
| br_valid | input | 1 | Branch strobe |
| br_pc | input | ADDR_W | Address of the branch instruction |
| br_insn | input | OFF_W+SEL_W+2 | Branch instruction word: form bits, selector, offset |
| res_valid | output | 1 | One-cycle pulse for a resolved branch |
| res_taken | output | 1 | Branch condition held |
| res_illegal | output | 1 | Selector was not a defined relation |
| res_next_pc | output | ADDR_W | Next fetch address |

## Verification
Every selector value, legal and illegal, is applied to every pair drawn from a set of operand corners: zero, one, five, the most positive value, the most negative value and all-ones. Pairs such as the most negative value against one separate the signed relations from the unsigned ones, and pairs with equal operands separate the strict relations from the inclusive ones. Offsets at zero, +1022, -1024 and -2 check the sign extension and scaling, and a branch address near zero checks wrap-around. Separate sequences cover a compare in the same cycle as a branch, operand changes while no compare is strobed, and words whose form bits are not 11.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  // Relation selector codes; the numeric order is part of the instruction set.
  localparam logic [3:0] REL_EQ  = 4'd0;
  localparam logic [3:0] REL_NE  = 4'd1;
  localparam logic [3:0] REL_LT  = 4'd2;
  localparam logic [3:0] REL_GT  = 4'd3;
  localparam logic [3:0] REL_LTU = 4'd4;
  localparam logic [3:0] REL_GTU = 4'd5;
  localparam logic [3:0] REL_GE  = 4'd6;
  localparam logic [3:0] REL_LE  = 4'd7;
  localparam logic [3:0] REL_GEU = 4'd8;
  localparam logic [3:0] REL_LEU = 4'd9;

  // Basic outcomes of comparing the two latched operands.
  typedef struct packed {
    logic eq;
    logic slt;
    logic ult;
  } cmp_flags_t;
endpackage

// File: rtl/cbr_operand_latch.sv
module cbr_operand_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/cbr_relation.sv
module cbr_relation
  import cbr_pkg::*;
#(
  parameter int W     = 32,
  parameter int SEL_W = 4
) (
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  input  logic [SEL_W-1:0] sel,
  output logic             hit,
  output logic             legal
);
  cmp_flags_t f;

  always_comb begin
    f.eq  = (opa == opb);
    f.slt = ($signed(opa) < $signed(opb));
    f.ult = (opa < opb);
  end

  always_comb begin
    hit   = 1'b0;
    legal = 1'b1;
    case (sel)
      REL_EQ:  hit = f.eq;
      REL_NE:  hit = !f.eq;
      REL_LT:  hit = f.slt;
      REL_GT:  hit = !f.slt && !f.eq;
      REL_LTU: hit = f.ult;
      REL_GTU: hit = !f.ult && !f.eq;
      REL_GE:  hit = !f.slt;
      REL_LE:  hit = f.slt || f.eq;
      REL_GEU: hit = !f.ult;
      REL_LEU: hit = f.ult || f.eq;
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbr_target.sv
module cbr_target #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 10
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  off_field,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] jump_pc
);
  localparam int EXT_W = ADDR_W - OFF_W - 1;
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(2);

  logic [ADDR_W-1:0] disp;

  always_comb begin
    disp    = {{EXT_W{off_field[OFF_W-1]}}, off_field, 1'b0};
    seq_pc  = pc + INSN_BYTES;
    jump_pc = seq_pc + disp;
  end
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 10,
  parameter int SEL_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmp_valid,
  input  logic [DATA_W-1:0]        cmp_lhs,
  input  logic [DATA_W-1:0]        cmp_rhs,
  input  logic                     br_valid,
  input  logic [ADDR_W-1:0]        br_pc,
  input  logic [OFF_W+SEL_W+1:0]   br_insn,
  output logic                     res_valid,
  output logic                     res_taken,
  output logic                     res_illegal,
  output logic [ADDR_W-1:0]        res_next_pc
);
  localparam int INSN_W = OFF_W + SEL_W + 2;
  localparam int NUM_OPS = 2;

  logic [NUM_OPS-1:0][DATA_W-1:0] op_in;
  logic [NUM_OPS-1:0][DATA_W-1:0] op_q;
  logic [DATA_W-1:0]              lat_a;
  logic [DATA_W-1:0]              lat_b;

  assign op_in[0] = cmp_lhs;
  assign op_in[1] = cmp_rhs;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_lat
    cbr_operand_latch #(.W(DATA_W)) u_lat (
      .clk  (clk),
      .rst  (rst),
      .load (cmp_valid),
      .d    (op_in[i]),
      .q    (op_q[i])
    );
  end

  assign lat_a = op_q[0];
  assign lat_b = op_q[1];

  logic [SEL_W-1:0] sel;
  logic [OFF_W-1:0] off_field;
  logic             form_ok;
  logic             accept;

  assign sel       = br_insn[OFF_W +: SEL_W];
  assign off_field = br_insn[OFF_W-1:0];
  assign form_ok   = (br_insn[INSN_W-1 -: 2] == 2'b11);
  assign accept    = br_valid && form_ok;

  logic hit;
  logic legal;

  cbr_relation #(.W(DATA_W), .SEL_W(SEL_W)) u_rel (
    .opa   (lat_a),
    .opb   (lat_b),
    .sel   (sel),
    .hit   (hit),
    .legal (legal)
  );

  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] jump_pc;

  cbr_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
    .pc        (br_pc),
    .off_field (off_field),
    .seq_pc    (seq_pc),
    .jump_pc   (jump_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_taken   <= 1'b0;
      res_illegal <= 1'b0;
      res_next_pc <= '0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        res_taken   <= legal && hit;
        res_illegal <= !legal;
        if (!legal)   res_next_pc <= br_pc;
        else if (hit) res_next_pc <= jump_pc;
        else          res_next_pc <= seq_pc;
      end
    end
  end
endmodule

// File: rtl/cond_branch_unit_chk.sv
module cond_branch_unit_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 10,
  parameter int SEL_W  = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cmp_valid,
  input logic                   br_valid,
  input logic [ADDR_W-1:0]      br_pc,
  input logic [OFF_W+SEL_W+1:0] br_insn,
  input logic                   res_valid,
  input logic                   res_taken,
  input logic                   res_illegal,
  input logic [ADDR_W-1:0]      res_next_pc,
  input logic [DATA_W-1:0]      lat_a,
  input logic [DATA_W-1:0]      lat_b
);
  localparam int TOP = OFF_W + SEL_W + 1;

  AST_VALID_AFTER_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_insn[TOP -: 2] == 2'b11) |=> res_valid);  // R9

  AST_NO_RESULT_WITHOUT_BRANCH: assert property (@(posedge clk) disable iff (rst)
    !(br_valid && br_insn[TOP -: 2] == 2'b11) |=> !res_valid);  // R8

  AST_ILLEGAL_KEEPS_PC: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_insn[TOP -: 2] == 2'b11 && br_insn[OFF_W +: SEL_W] > SEL_W'(9))
    |=> (res_illegal && !res_taken && res_next_pc == $past(br_pc)));  // R7

  AST_FALLTHROUGH_ADDR: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_taken && !res_illegal) |-> res_next_pc == $past(br_pc) + ADDR_W'(2));  // R6

  AST_LATCH_A_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(cmp_valid) |-> $stable(lat_a));  // R2

  AST_LATCH_B_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(cmp_valid) |-> $stable(lat_b));  // R2

  AST_TAKEN_IS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    res_taken |-> !res_illegal);  // R7
endmodule

bind cond_branch_unit cond_branch_unit_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SEL_W(SEL_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmp_valid   (cmp_valid),
  .br_valid    (br_valid),
  .br_pc       (br_pc),
  .br_insn     (br_insn),
  .res_valid   (res_valid),
  .res_taken   (res_taken),
  .res_illegal (res_illegal),
  .res_next_pc (res_next_pc),
  .lat_a       (lat_a),
  .lat_b       (lat_b)
);

// File: tb/cond_branch_unit_bench.sv
`timescale 1ns/1ps
module cond_branch_unit_bench;
  localparam real CLK_PERIOD = 4.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_valid = 1'b0;
  logic [31:0] cmp_lhs = '0;
  logic [31:0] cmp_rhs = '0;
  logic        br_valid = 1'b0;
  logic [31:0] br_pc = '0;
  logic [15:0] br_insn = '0;
  logic        res_valid;
  logic        res_taken;
  logic        res_illegal;
  logic [31:0] res_next_pc;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_branch_unit u_cond_branch_unit (
    .clk(clk), .rst(rst),
    .cmp_valid(cmp_valid), .cmp_lhs(cmp_lhs), .cmp_rhs(cmp_rhs),
    .br_valid(br_valid), .br_pc(br_pc), .br_insn(br_insn),
    .res_valid(res_valid), .res_taken(res_taken),
    .res_illegal(res_illegal), .res_next_pc(res_next_pc)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  function automatic bit ref_rel(int c, logic [31:0] a, logic [31:0] b);
    case (c)
      0: return a == b;
      1: return a != b;
      2: return $signed(a) <  $signed(b);
      3: return $signed(a) >  $signed(b);
      4: return a <  b;
      5: return a >  b;
      6: return $signed(a) >= $signed(b);
      7: return $signed(a) <= $signed(b);
      8: return a >= b;
      9: return a <= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] mk_insn(int code, logic [9:0] off);
    return {2'b11, 4'(code), off};
  endfunction

  function automatic logic [31:0] off_bytes(logic [9:0] off);
    int v;
    v = (off >= 10'd512) ? int'(off) - 1024 : int'(off);
    return 32'(v * 2);
  endfunction

  task automatic do_compare(logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_lhs = a; cmp_rhs = b;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  // Issue one branch, sample one cycle later, then check against the model.
  task automatic branch_check(string req, logic [31:0] a, logic [31:0] b,
                              int code, logic [31:0] pc, logic [9:0] off);
    bit t;
    logic [31:0] exp_pc;
    @(negedge clk);
    br_valid = 1'b1; br_pc = pc; br_insn = mk_insn(code, off);
    @(posedge clk); #1;
    br_valid = 1'b0;
    t = ref_rel(code, a, b);
    if (code > 9) exp_pc = pc;
    else if (t) exp_pc = pc + 32'd2 + off_bytes(off);
    else exp_pc = pc + 32'd2;
    check(req, "valid", 32'(res_valid), 32'd1);
    check(req, "taken", 32'(res_taken), 32'(t && code <= 9));
    check(req, "illegal", 32'(res_illegal), 32'(code > 9));
    check(req, "next_pc", res_next_pc, exp_pc);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] corners [6];
    logic [9:0]  offs [4];
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'h0000_0005; corners[3] = 32'h7fff_ffff;
    corners[4] = 32'h8000_0000; corners[5] = 32'hffff_ffff;
    offs[0] = 10'h000; offs[1] = 10'h1ff; offs[2] = 10'h200; offs[3] = 10'h3ff;

    repeat (3) @(posedge clk);
    #1;
    // R1: reset state of the outputs
    check("R1", "valid", 32'(res_valid), 32'd0);
    check("R1", "taken", 32'(res_taken), 32'd0);
    check("R1", "illegal", 32'(res_illegal), 32'd0);
    check("R1", "next_pc", res_next_pc, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R1: latches cleared, so equal holds on the first branch
    branch_check("R1", 32'd0, 32'd0, 0, 32'h0000_1000, 10'h004);

    // R9: valid drops the cycle after a single branch
    @(posedge clk); #1;
    check("R9", "valid_drop", 32'(res_valid), 32'd0);

    // R4 / R7: every selector against every corner pair
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        do_compare(corners[i], corners[j]);
        for (int c = 0; c < 16; c++) begin
          branch_check(c > 9 ? "R7" : "R4", corners[i], corners[j], c,
                       32'h0000_4000 + 32'(c * 16), 10'(c * 3));
        end
      end
    end

    // R5 / R6: offsets at the extremes, with taken and not-taken outcomes
    do_compare(32'd7, 32'd7);
    for (int k = 0; k < 4; k++) begin
      branch_check("R5", 32'd7, 32'd7, 0, 32'h0001_0000, offs[k]);
      branch_check("R6", 32'd7, 32'd7, 1, 32'h0001_0000, offs[k]);
    end
    // R5: wrap-around below address zero
    branch_check("R5", 32'd7, 32'd7, 0, 32'h0000_0002, 10'h200);

    // R2: operand inputs move without a strobe; latches must hold 7/7
    @(negedge clk);
    cmp_lhs = 32'd1; cmp_rhs = 32'd2;
    repeat (2) @(negedge clk);
    branch_check("R2", 32'd7, 32'd7, 0, 32'h0000_2000, 10'h010);

    // R3: compare together with a branch sees the old pair
    @(negedge clk);
    cmp_valid = 1'b1; cmp_lhs = 32'd1; cmp_rhs = 32'd2;
    br_valid = 1'b1; br_pc = 32'h0000_3000; br_insn = mk_insn(0, 10'h020);
    @(posedge clk); #1;
    cmp_valid = 1'b0; br_valid = 1'b0;
    check("R3", "taken_old", 32'(res_taken), 32'd1);
    check("R3", "next_pc_old", res_next_pc, 32'h0000_3042);
    branch_check("R3", 32'd1, 32'd2, 0, 32'h0000_3000, 10'h020);

    // R8: wrong form bits give no result and leave outputs unchanged
    for (int f = 0; f < 3; f++) begin
      @(negedge clk);
      br_valid = 1'b1; br_pc = 32'h0000_5000;
      br_insn = {2'(f), 4'd0, 10'h008};
      @(posedge clk); #1;
      br_valid = 1'b0;
      check("R8", "no_valid", 32'(res_valid), 32'd0);
      check("R8", "pc_kept", res_next_pc, 32'h0000_3002);
    end
    // R8: selector sits in bits 13:10 (code 2, signed less, 1 < 2)
    branch_check("R8", 32'd1, 32'd2, 2, 32'h0000_6000, 10'h001);

    // R9: back-to-back branches keep valid high, then it falls
    @(negedge clk);
    br_valid = 1'b1; br_pc = 32'h0000_7000; br_insn = mk_insn(1, 10'h0);
    @(posedge clk); #1;
    check("R9", "first", 32'(res_valid), 32'd1);
    @(posedge clk); #1;
    check("R9", "second", 32'(res_valid), 32'd1);
    @(negedge clk); br_valid = 1'b0;
    @(posedge clk); #1;
    check("R9", "fall", 32'(res_valid), 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule